// File: doc/BRIEF.md
# Infrared Remote Carrier Synthesizer

This block produces a modulation carrier for an infrared remote-control transmitter and places it on a single push-pull output pin. The carrier is built by dividing the system oscillator clock. A two-bit selector picks one of four settings. Setting 0 turns the carrier off. Setting 1 divides the clock by eight at half duty. Setting 2 divides it by twelve at half duty. Setting 3 divides it by twelve with the output high for one third of each period. With a 455 kHz oscillator, the two ratios give about 56.9 kHz and about 37.9 kHz.

The pin also has a one-bit output data latch that firmware writes. When a carrier is selected, the latch bit acts as an enable: a high latch lets the carrier through and a low latch forces the pin low. When the carrier is off, the pin simply follows the latch. Any change of the selector restarts the divider from count zero, so the first period after a switch is always complete.

Top module: `irc_carrier`

## Requirements
- R1: While reset is asserted, the output latch and the divider count are held at 0 and `pin_out` is 0. After reset is released they start from those values.
- R2: With selector 2'b00 the divider count stays at 0 and `pin_out` equals the output latch bit.
- R3: With selector 2'b01 the divider has a period of DIV_A (8) clocks. The carrier is high for counts 0 to DIV_A/2-1 (counts 0 to 3) and low for the rest of the period.
- R4: With selector 2'b10 the divider has a period of DIV_B (12) clocks. The carrier is high for counts 0 to DIV_B/2-1 (counts 0 to 5).
- R5: With selector 2'b11 the divider has a period of DIV_B (12) clocks. The carrier is high for counts 0 to DIV_B/3-1 (counts 0 to 3) and low for counts 4 to 11.
- R6: With any selector other than 2'b00, `pin_out` is the carrier ANDed with the latch bit, so a latch of 0 holds the pin low.
- R7: When the selector input differs from the registered selector, the next clock loads the new selector and sets the count to 0. The new waveform then begins with a complete high phase.
- R8: The latch takes `pb_wr_data` on a clock edge where `pb_wr_en` is 1. Otherwise it keeps its value.
- R9: The divider count never reaches the period of the active setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock; it is also the carrier source |
| rst_n | input | 1 | Asynchronous active-low reset |
| car_sel | input | 2 | Carrier selector: 00 off, 01 divide-by-8 at half duty, 10 divide-by-12 at half duty, 11 divide-by-12 at one-third duty |
| pb_wr_en | input | 1 | Write strobe for the output latch |
| pb_wr_data | input | 1 | Value to load into the output latch |
| pin_out | output | 1 | Push-pull pin drive |

## Verification
A divider count that is off by one shows at the pin within one carrier period. It appears as a high phase or a period that is one clock too long or too short. A count that is not cleared on a selector change shows as a short first pulse within the first high phase after the switch. A latch that loses its value shows on the next cycle, because the pin is then held low or fails to follow the latch in off mode. Random selector changes with random hold lengths, mixed with directed switches in the middle of a phase, compare the pin every cycle against a cycle-accurate model in the bench.

// File: rtl/irc_pkg.sv
package irc_pkg;

  typedef enum logic [1:0] {
    CAR_OFF  = 2'b00,
    CAR_D8   = 2'b01,
    CAR_D12H = 2'b10,
    CAR_D12T = 2'b11
  } car_mode_e;

  // Number of oscillator clocks in one carrier period for a setting.
  function automatic int unsigned car_period(car_mode_e m, int unsigned da,
                                             int unsigned db);
    case (m)
      CAR_D8:   car_period = da;
      CAR_D12H: car_period = db;
      CAR_D12T: car_period = db;
      default:  car_period = 1;
    endcase
  endfunction

  // Number of leading counts in a period during which the carrier is high.
  function automatic int unsigned car_high_len(car_mode_e m, int unsigned da,
                                               int unsigned db);
    case (m)
      CAR_D8:   car_high_len = da / 2;
      CAR_D12H: car_high_len = db / 2;
      CAR_D12T: car_high_len = db / 3;
      default:  car_high_len = 0;
    endcase
  endfunction

endpackage

// File: rtl/irc_divider.sv
module irc_divider
  import irc_pkg::*;
#(
  parameter int unsigned DIV_A = 8,
  parameter int unsigned DIV_B = 12,
  parameter int unsigned CW    = $clog2(DIV_B)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  car_mode_e     mode_in,
  output car_mode_e     mode_q,
  output logic [CW-1:0] cnt,
  output logic          mode_switch,
  output logic          cnt_wrap
);

  int unsigned per;

  always_comb begin
    per         = car_period(mode_q, DIV_A, DIV_B);
    mode_switch = (mode_in != mode_q);
    cnt_wrap    = (mode_q != CAR_OFF) && (32'(cnt) == per - 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= CAR_OFF;
      cnt    <= '0;
    end else begin
      mode_q <= mode_in;
      if (mode_switch || mode_q == CAR_OFF || cnt_wrap)
        cnt <= '0;
      else
        cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/irc_shaper.sv
module irc_shaper
  import irc_pkg::*;
#(
  parameter int unsigned DIV_A = 8,
  parameter int unsigned DIV_B = 12,
  parameter int unsigned CW    = $clog2(DIV_B)
) (
  input  car_mode_e     mode_q,
  input  logic [CW-1:0] cnt,
  output logic          carrier_raw
);

  always_comb begin
    carrier_raw = (mode_q != CAR_OFF) &&
                  (32'(cnt) < car_high_len(mode_q, DIV_A, DIV_B));
  end

endmodule

// File: rtl/irc_pin_gate.sv
module irc_pin_gate
  import irc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      wr_data,
  input  car_mode_e mode_q,
  input  logic      carrier_raw,
  output logic      latch_q,
  output logic      pin_drive
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      latch_q <= 1'b0;
    else if (wr_en)
      latch_q <= wr_data;
  end

  always_comb begin
    if (mode_q == CAR_OFF)
      pin_drive = latch_q;
    else
      pin_drive = carrier_raw & latch_q;
  end

endmodule

// File: rtl/irc_carrier.sv
module irc_carrier
  import irc_pkg::*;
#(
  parameter int unsigned DIV_A = 8,
  parameter int unsigned DIV_B = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] car_sel,
  input  logic       pb_wr_en,
  input  logic       pb_wr_data,
  output logic       pin_out
);

  localparam int unsigned CW = $clog2(DIV_B);

  car_mode_e     mode_q;
  logic [CW-1:0] cnt;
  logic          mode_switch;
  logic          cnt_wrap;
  logic          carrier_raw;
  logic          latch_q;

  irc_divider #(.DIV_A(DIV_A), .DIV_B(DIV_B), .CW(CW)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_in     (car_mode_e'(car_sel)),
    .mode_q      (mode_q),
    .cnt         (cnt),
    .mode_switch (mode_switch),
    .cnt_wrap    (cnt_wrap)
  );

  irc_shaper #(.DIV_A(DIV_A), .DIV_B(DIV_B), .CW(CW)) u_shape (
    .mode_q      (mode_q),
    .cnt         (cnt),
    .carrier_raw (carrier_raw)
  );

  irc_pin_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (pb_wr_en),
    .wr_data     (pb_wr_data),
    .mode_q      (mode_q),
    .carrier_raw (carrier_raw),
    .latch_q     (latch_q),
    .pin_drive   (pin_out)
  );

endmodule

// File: rtl/irc_carrier_chk.sv
module irc_carrier_chk
  import irc_pkg::*;
#(
  parameter int unsigned DIV_A = 8,
  parameter int unsigned DIV_B = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      pb_wr_en,
  input logic [1:0]                mode_q,
  input logic [$clog2(DIV_B)-1:0]  cnt,
  input logic                      mode_switch,
  input logic                      cnt_wrap,
  input logic                      carrier_raw,
  input logic                      latch_q,
  input logic                      pin_out
);

  localparam int unsigned CW = $clog2(DIV_B);

  always @(posedge clk) begin
    if (!rst_n) AST_RESET_LOW: assert (pin_out == 1'b0 && cnt == '0); // R1
  end

  AST_OFF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b00) |-> (cnt == '0 && pin_out == latch_q)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b00 && !mode_switch && !cnt_wrap)
      |=> (cnt == CW'($past(cnt) + 1'b1))); // R3

  AST_PHASE_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != 2'b00 && cnt == '0) |-> carrier_raw); // R4

  AST_THIRD_LOW_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'b11 && 32'(cnt) >= DIV_B / 3) |-> !carrier_raw); // R5

  AST_LATCH_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_q |-> !pin_out); // R6

  AST_SWITCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    mode_switch |=> (cnt == '0)); // R7

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pb_wr_en |=> $stable(latch_q)); // R8

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < car_period(car_mode_e'(mode_q), DIV_A, DIV_B)); // R9

endmodule

bind irc_carrier irc_carrier_chk #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pb_wr_en    (pb_wr_en),
  .mode_q      (mode_q),
  .cnt         (cnt),
  .mode_switch (mode_switch),
  .cnt_wrap    (cnt_wrap),
  .carrier_raw (carrier_raw),
  .latch_q     (latch_q),
  .pin_out     (pin_out)
);

// File: tb/irc_carrier_bench.sv
module irc_carrier_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] car_sel = 2'b00;
  logic       pb_wr_en = 1'b0;
  logic       pb_wr_data = 1'b0;
  logic       pin_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irc_carrier u_irc_carrier (
    .clk        (clk),
    .rst_n      (rst_n),
    .car_sel    (car_sel),
    .pb_wr_en   (pb_wr_en),
    .pb_wr_data (pb_wr_data),
    .pin_out    (pin_out)
  );

  // Reference model, written from the requirements.
  logic [1:0] m_sel;
  int         m_cnt;
  logic       m_lat;

  function automatic int ref_len(logic [1:0] s);
    return (s == 2'b01) ? 8 : 12;
  endfunction

  function automatic logic ref_hi(logic [1:0] s, int c);
    case (s)
      2'b01:   return c <= 3;
      2'b10:   return c <= 5;
      2'b11:   return 3 * c < 12;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic ref_pin(logic [1:0] s, int c, logic l);
    if (s == 2'b00) return l;
    return l & ref_hi(s, c);
  endfunction

  function automatic string tag_of(logic [1:0] s, logic l);
    if (s == 2'b00) return "R2";
    if (!l) return "R6";
    if (s == 2'b01) return "R3";
    if (s == 2'b10) return "R4";
    return "R5";
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sel <= 2'b00;
      m_cnt <= 0;
      m_lat <= 1'b0;
    end else begin
      m_sel <= car_sel;
      if (car_sel != m_sel || m_sel == 2'b00) m_cnt <= 0;
      else if (m_cnt == ref_len(m_sel) - 1) m_cnt <= 0;
      else m_cnt <= m_cnt + 1;
      if (pb_wr_en) m_lat <= pb_wr_data;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pin_out=%0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Check outputs at the falling edge, then drive the next inputs.
  task automatic step(string tag, logic [1:0] s, logic we, logic d);
    @(negedge clk);
    chk((tag == "") ? tag_of(m_sel, m_lat) : tag, pin_out, ref_pin(m_sel, m_cnt, m_lat));
    car_sel = s;
    pb_wr_en = we;
    pb_wr_data = d;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // R1: reset holds the pin low even while stimulus tries to set the latch
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", pin_out, 1'b0);
      car_sel = 2'b01; pb_wr_en = 1'b1; pb_wr_data = 1'b1;
    end
    @(negedge clk);
    car_sel = 2'b00; pb_wr_en = 1'b0; pb_wr_data = 1'b0;
    rst_n = 1'b1;
    step("R1", 2'b00, 1'b0, 1'b0);
    // R8: data without the write strobe is ignored; pin stays low in off mode
    for (int i = 0; i < 3; i++) step("R8", 2'b00, 1'b0, 1'b1);
    step("R8", 2'b00, 1'b1, 1'b1);
    for (int i = 0; i < 3; i++) step("R8", 2'b00, 1'b0, 1'b0);
    // R3, R4, R5: two full periods of each carrier with the latch high
    for (int i = 0; i < 17; i++) step("R3", 2'b01, 1'b0, 1'b0);
    for (int i = 0; i < 25; i++) step("R4", 2'b10, 1'b0, 1'b0);
    for (int i = 0; i < 25; i++) step("R5", 2'b11, 1'b0, 1'b0);
    // R7: switch in the middle of a high phase, then in the middle of a low phase
    for (int i = 0; i < 3; i++) step("R7", 2'b01, 1'b0, 1'b0);
    for (int i = 0; i < 14; i++) step("R7", 2'b10, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) step("R7", 2'b11, 1'b0, 1'b0);
    for (int i = 0; i < 9; i++) step("R7", 2'b01, 1'b0, 1'b0);
    // R6: latch cleared while a carrier is running
    step("R6", 2'b01, 1'b1, 1'b0);
    for (int i = 0; i < 10; i++) step("R6", 2'b01, 1'b0, 1'b0);
    // R9 and the rest: random selector with random hold times and latch writes
    for (int b = 0; b < 400; b++) begin
      logic [1:0] s = 2'($urandom_range(0, 3));
      int hold = $urandom_range(1, 30);
      for (int i = 0; i < hold; i++) begin
        logic we = ($urandom_range(0, 9) == 0);
        step((i == 0) ? "R7" : "", s, we, 1'($urandom_range(0, 3) != 0));
      end
    end
    step("R9", 2'b00, 1'b0, 1'b0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule